// File: doc/BRIEF.md
# Implied-Address Generation Unit

This unit produces the bus address for memory references whose address is held in a pointer register. It keeps six pointer registers and the program counter. It applies the update rule of the selected register on every bus access: a fixed pointer, a post-incremented pointer, or a stack pointer that is pre-decremented on reads and post-incremented on writes. An immediate-mode reference takes its operand from the word that the program counter points at.

A one-shot double-byte prefix can be armed before a reference. A read that follows an armed prefix makes two byte-wide accesses. The low byte of each access is kept, and the two bytes are joined into one 16-bit result. The unit issues one access at a time and waits for a one-cycle acknowledge. It pulses `done_o` once the operand is complete. A register load port and a register view port connect the unit to the surrounding datapath.

Top module: `ptr_addr_unit`

## Requirements
- R1: With selector 1, 2 or 3 (registers R1..R3), the access address is the register value and the register is left unchanged.
- R2: With selector 4 or 5, the access uses the register value and the register increments by one after each acknowledged access.
- R3: With selector 6 on a write, the access address is R6 and R6 increments by one afterwards; `bus_wdata_o` carries `wdata_i`.
- R4: With selector 6 on a read, the access address is R6-1 and R6 holds R6-1 afterwards.
- R5: An immediate reference (`imm_i`=1, selector ignored) without an armed prefix makes one read at PC, returns the full word on `rdata_o`, and leaves PC+1. `done_o` is high for one cycle, in the cycle after the final acknowledge.
- R6: A read with an armed prefix and selector 1..3 makes two accesses to the same address with `bus_byte_o`=1. The result is {second low byte, first low byte}, and the register is unchanged.
- R7: A read with an armed prefix and selector 4 or 5 (value p) reads p, then p+1, each with `bus_byte_o`=1. The result is {low byte of p+1, low byte of p}, and the register ends at p+2.
- R8: An immediate reference with an armed prefix reads PC and PC+1 as bytes, returns {low of PC+1, low of PC}, and leaves PC+2.
- R9: The prefix, armed by a `pfx_i` pulse, applies only to the next request. The request after that makes a single full-word access.
- R10: A non-immediate request with selector 0 or 7 raises `err_o` for one cycle. It issues no bus access, leaves every register unchanged, and consumes the prefix.
- R11: A write with an armed prefix is still one full-word access with `bus_byte_o`=0. The prefix is consumed, and the pointer rule of R2/R3 applies once.
- R12: After reset all registers read 0, and `done_o`, `err_o` and `bus_req_o` are low. On the load and view ports, index 1..6 selects R1..R6, index 7 selects PC, and a view of index 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a reference (sampled when idle) |
| sel_i | input | 3 | Pointer selector |
| wr_i | input | 1 | 1 = write reference |
| imm_i | input | 1 | Immediate reference through PC |
| pfx_i | input | 1 | Arm the double-byte prefix |
| wdata_i | input | 16 | Write data |
| ld_i | input | 1 | Load a register |
| ld_idx_i | input | 3 | Register to load (7 = PC) |
| ld_val_i | input | 16 | Load value |
| view_idx_i | input | 3 | Register to view |
| view_val_o | output | 16 | Viewed register value |
| bus_req_o | output | 1 | Access in progress |
| bus_addr_o | output | 16 | Access address |
| bus_we_o | output | 1 | Access is a write |
| bus_byte_o | output | 1 | Only the low byte lane is used |
| bus_wdata_o | output | 16 | Data for write accesses |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 16 | Read data |
| done_o | output | 1 | Operand complete (one-cycle pulse) |
| rdata_o | output | 16 | Assembled read result |
| err_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
The bench aims at the asymmetric stack rule. A design that decrements after the read instead of before it reads the wrong slot, so a push-then-pop pair does not give the pushed word back. With the prefix armed, it checks three things. R1..R3 must not advance between the two byte reads, or the second byte comes from the next word. R4/R5 and PC must end two ahead, not one. The bytes must land in the right halves. It also checks that the prefix does not persist: a sticky flag would turn the next ordinary read into two byte accesses. Finally it checks that a rejected selector issues no bus cycle and moves no pointer.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seq_st_e;
  localparam logic [2:0] IDX_SP = 3'd6;
  localparam logic [2:0] IDX_PC = 3'd7;
  localparam int unsigned NUM_IDX = 8;
endpackage

// File: rtl/ptr_regs.sv
module ptr_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [2:0]   ld_idx_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         upd_i,
  input  logic [2:0]   upd_idx_i,
  input  logic [W-1:0] upd_val_i,
  input  logic [2:0]   a_idx_i,
  output logic [W-1:0] a_val_o,
  input  logic [2:0]   b_idx_i,
  output logic [W-1:0] b_val_o
);
  import ptr_addr_pkg::*;

  logic [W-1:0] regs [NUM_IDX];

  assign regs[0] = '0;

  for (genvar g = 1; g < NUM_IDX; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs[g] <= '0;
      else if (upd_i && upd_idx_i == 3'(g))          regs[g] <= upd_val_i;
      else if (ld_i && ld_idx_i == 3'(g))            regs[g] <= ld_val_i;
    end
  end

  assign a_val_o = regs[a_idx_i];
  assign b_val_o = regs[b_idx_i];
endmodule

// File: rtl/ptr_seq.sv
module ptr_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [2:0]   sel_i,
  input  logic         wr_i,
  input  logic         imm_i,
  input  logic         pfx_i,
  input  logic [W-1:0] wdata_i,
  output logic [2:0]   idx_o,
  input  logic [W-1:0] cur_i,
  output logic         upd_o,
  output logic [W-1:0] upd_val_o,
  output logic         bus_req_o,
  output logic [W-1:0] bus_addr_o,
  output logic         bus_we_o,
  output logic         bus_byte_o,
  output logic [W-1:0] bus_wdata_o,
  input  logic         bus_ack_i,
  input  logic [W-1:0] bus_rdata_i,
  output logic         done_o,
  output logic [W-1:0] rdata_o,
  output logic         err_o
);
  import ptr_addr_pkg::*;
  localparam int unsigned BYTE_W = W / 2;

  seq_st_e           st_q;
  logic [2:0]        idx_q;
  logic              wr_q, dbl_q, armed_q, done_q, err_q;
  logic [W-1:0]      wdat_q, res_q;
  logic [BYTE_W-1:0] lo_q;
  logic              sel_ok, wr_eff, pop, acc;

  assign sel_ok = imm_i || (sel_i != 3'd0 && sel_i != IDX_PC);
  assign wr_eff = wr_i && !imm_i;
  assign pop    = (idx_q == IDX_SP) && !wr_q;
  assign acc    = (st_q != ST_IDLE) && bus_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      dbl_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wdat_q  <= '0;
      res_q   <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (pfx_i)                         armed_q <= 1'b1;
      else if (st_q == ST_IDLE && req_i) armed_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (!sel_ok) err_q <= 1'b1;
          else begin
            idx_q  <= imm_i ? IDX_PC : sel_i;
            wr_q   <= wr_eff;
            dbl_q  <= armed_q && !wr_eff;  // prefix only splits reads
            wdat_q <= wdata_i;
            st_q   <= ST_FIRST;
          end
        end
        ST_FIRST: if (bus_ack_i) begin
          if (dbl_q) begin
            lo_q <= bus_rdata_i[BYTE_W-1:0];
            st_q <= ST_SECOND;
          end else begin
            if (!wr_q) res_q <= bus_rdata_i;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_SECOND: if (bus_ack_i) begin
          res_q  <= {bus_rdata_i[BYTE_W-1:0], lo_q};
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_addr_o  = pop ? cur_i - W'(1) : cur_i;
  assign bus_we_o    = bus_req_o && wr_q;
  assign bus_byte_o  = bus_req_o && dbl_q;
  assign bus_wdata_o = wdat_q;
  assign upd_o       = acc && (idx_q >= 3'd4);
  assign upd_val_o   = pop ? cur_i - W'(1) : cur_i + W'(1);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = res_q;

  // R6
  fixed_ptr_same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRST && bus_ack_i && dbl_q && idx_q <= 3'd3) |=> bus_addr_o == $past(bus_addr_o));
  // R7
  inc_ptr_next_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRST && bus_ack_i && dbl_q && (idx_q == 3'd4 || idx_q == 3'd5))
    |=> bus_addr_o == $past(bus_addr_o) + W'(1));
  // R4
  pop_settles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && idx_q == IDX_SP && !wr_q) |=> cur_i == $past(bus_addr_o));
  // R10
  reject_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_req_o);
  // R11
  byte_lane_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_byte_o |-> !bus_we_o);
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [2:0]   sel_i,
  input  logic         wr_i,
  input  logic         imm_i,
  input  logic         pfx_i,
  input  logic [W-1:0] wdata_i,
  input  logic         ld_i,
  input  logic [2:0]   ld_idx_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [2:0]   view_idx_i,
  output logic [W-1:0] view_val_o,
  output logic         bus_req_o,
  output logic [W-1:0] bus_addr_o,
  output logic         bus_we_o,
  output logic         bus_byte_o,
  output logic [W-1:0] bus_wdata_o,
  input  logic         bus_ack_i,
  input  logic [W-1:0] bus_rdata_i,
  output logic         done_o,
  output logic [W-1:0] rdata_o,
  output logic         err_o
);
  logic [2:0]   idx;
  logic [W-1:0] cur, upd_val;
  logic         upd;

  ptr_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni,
    .ld_i, .ld_idx_i, .ld_val_i,
    .upd_i(upd), .upd_idx_i(idx), .upd_val_i(upd_val),
    .a_idx_i(idx), .a_val_o(cur),
    .b_idx_i(view_idx_i), .b_val_o(view_val_o)
  );

  ptr_seq #(.W(W)) u_seq (
    .clk_i, .rst_ni,
    .req_i, .sel_i, .wr_i, .imm_i, .pfx_i, .wdata_i,
    .idx_o(idx), .cur_i(cur), .upd_o(upd), .upd_val_o(upd_val),
    .bus_req_o, .bus_addr_o, .bus_we_o, .bus_byte_o, .bus_wdata_o,
    .bus_ack_i, .bus_rdata_i,
    .done_o, .rdata_o, .err_o
  );
endmodule

// File: tb/sim_ptr_addr_unit.sv
module sim_ptr_addr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, wr = 0, imm = 0, pfx = 0, ld = 0;
  logic [2:0] sel = 0, ld_idx = 0, view_idx = 0;
  logic [15:0] wdata = 0, ld_val = 0;
  logic [15:0] view_val, bus_addr, bus_wdata, rdata, bus_rdata;
  logic bus_req, bus_we, bus_byte, done, err;
  logic [15:0] mem [256];
  int checks = 0, errors = 0, acc_cnt = 0, byte_cnt = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  ptr_addr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .wr_i(wr), .imm_i(imm),
    .pfx_i(pfx), .wdata_i(wdata), .ld_i(ld), .ld_idx_i(ld_idx), .ld_val_i(ld_val),
    .view_idx_i(view_idx), .view_val_o(view_val), .bus_req_o(bus_req),
    .bus_addr_o(bus_addr), .bus_we_o(bus_we), .bus_byte_o(bus_byte),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_req), .bus_rdata_i(bus_rdata),
    .done_o(done), .rdata_o(rdata), .err_o(err)
  );

  assign bus_rdata = mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= {~8'(i), 8'(i)};
    end else if (bus_req && bus_we) mem[bus_addr[7:0]] <= bus_wdata;
  end

  always @(negedge clk) if (bus_req) begin
    acc_cnt <= acc_cnt + 1;
    if (bus_byte) byte_cnt <= byte_cnt + 1;
  end

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return {~a[7:0], a[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk); ld = 1; ld_idx = idx; ld_val = v;
    @(negedge clk); ld = 0;
  endtask

  task automatic view(input logic [2:0] idx, output logic [15:0] v);
    view_idx = idx; #1; v = view_val;
  endtask

  task automatic arm();
    @(negedge clk); pfx = 1;
    @(negedge clk); pfx = 0;
  endtask

  task automatic ref_op(input logic [2:0] s, input logic w, input logic im,
                        input logic [15:0] d, output int nacc, output int nbyte,
                        output logic got_err);
    int a0, b0;
    a0 = acc_cnt; b0 = byte_cnt; got_err = 0;
    @(negedge clk); req = 1; sel = s; wr = w; imm = im; wdata = d;
    @(negedge clk); req = 0;
    for (int k = 0; k < 20; k++) begin
      if (done || err) begin got_err = err; break; end
      @(negedge clk);
    end
    @(negedge clk);
    nacc = acc_cnt - a0; nbyte = byte_cnt - b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      view(3'(i), v); chk("R12 reg zero", v, 16'h0);
    end
    chk("R12 idle outputs", {13'b0, done, err, bus_req}, 16'h0);
  endtask

  task automatic t_fixed();
    logic [15:0] v; int n, b; logic e;
    load(3'd2, 16'h0010);
    ref_op(3'd2, 0, 0, 0, n, b, e);
    chk("R1 data", rdata, word_at(16'h0010));
    view(3'd2, v); chk("R1 unchanged", v, 16'h0010);
    chk("R1 one access", 16'(n), 16'd1);
  endtask

  task automatic t_inc();
    logic [15:0] v; int n, b; logic e;
    load(3'd4, 16'h0020);
    ref_op(3'd4, 0, 0, 0, n, b, e);
    chk("R2 data", rdata, word_at(16'h0020));
    view(3'd4, v); chk("R2 post-inc", v, 16'h0021);
    load(3'd5, 16'h0030);
    ref_op(3'd5, 1, 0, 16'h1234, n, b, e);
    chk("R2 write mem", mem[8'h30], 16'h1234);
    view(3'd5, v); chk("R2 R5 post-inc", v, 16'h0031);
  endtask

  task automatic t_stack();
    logic [15:0] v; int n, b; logic e;
    load(3'd6, 16'h0040);
    ref_op(3'd6, 1, 0, 16'hBEEF, n, b, e);
    chk("R3 push mem", mem[8'h40], 16'hBEEF);
    view(3'd6, v); chk("R3 push inc", v, 16'h0041);
    ref_op(3'd6, 0, 0, 0, n, b, e);
    chk("R4 pop data", rdata, 16'hBEEF);
    view(3'd6, v); chk("R4 pop dec", v, 16'h0040);
  endtask

  task automatic t_imm();
    logic [15:0] v; int n, b; logic e;
    load(3'd7, 16'h0080);
    ref_op(3'd0, 0, 1, 0, n, b, e);
    chk("R5 imm data", rdata, word_at(16'h0080));
    view(3'd7, v); chk("R5 pc+1", v, 16'h0081);
    chk("R5 one access", 16'(n), 16'd1);
  endtask

  task automatic t_dbl_fixed();
    logic [15:0] v; int n, b; logic e;
    load(3'd3, 16'h0050); arm();
    ref_op(3'd3, 0, 0, 0, n, b, e);
    chk("R6 data", rdata, 16'h5050);
    view(3'd3, v); chk("R6 unchanged", v, 16'h0050);
    chk("R6 byte accesses", 16'(b), 16'd2);
  endtask

  task automatic t_dbl_inc();
    logic [15:0] v; int n, b; logic e;
    load(3'd4, 16'h0060); arm();
    ref_op(3'd4, 0, 0, 0, n, b, e);
    chk("R7 data", rdata, 16'h6160);
    view(3'd4, v); chk("R7 ptr+2", v, 16'h0062);
    chk("R7 two accesses", 16'(n), 16'd2);
    ref_op(3'd4, 0, 0, 0, n, b, e);
    chk("R9 single after", 16'(n), 16'd1);
    chk("R9 no byte lane", 16'(b), 16'd0);
    chk("R9 full word", rdata, word_at(16'h0062));
  endtask

  task automatic t_dbl_imm();
    logic [15:0] v; int n, b; logic e;
    load(3'd7, 16'h0070); arm();
    ref_op(3'd0, 0, 1, 0, n, b, e);
    chk("R8 data", rdata, 16'h7170);
    view(3'd7, v); chk("R8 pc+2", v, 16'h0072);
  endtask

  task automatic t_reject();
    logic [15:0] v; int n, b; logic e;
    load(3'd7, 16'h0090); arm();
    ref_op(3'd0, 0, 0, 0, n, b, e);
    chk("R10 err sel0", 16'(e), 16'd1);
    chk("R10 no access sel0", 16'(n), 16'd0);
    ref_op(3'd7, 1, 0, 16'h5555, n, b, e);
    chk("R10 err sel7", 16'(e), 16'd1);
    chk("R10 no access sel7", 16'(n), 16'd0);
    view(3'd7, v); chk("R10 pc unchanged", v, 16'h0090);
    ref_op(3'd0, 0, 1, 0, n, b, e);
    chk("R10 prefix consumed", 16'(n), 16'd1);
  endtask

  task automatic t_dbl_write();
    logic [15:0] v; int n, b; logic e;
    load(3'd5, 16'h00A0); arm();
    ref_op(3'd5, 1, 0, 16'hCAFE, n, b, e);
    chk("R11 one access", 16'(n), 16'd1);
    chk("R11 no byte lane", 16'(b), 16'd0);
    chk("R11 mem", mem[8'hA0], 16'hCAFE);
    view(3'd5, v); chk("R11 ptr+1", v, 16'h00A1);
    ref_op(3'd5, 0, 0, 0, n, b, e);
    chk("R11 prefix consumed", 16'(n), 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_fixed();
    t_inc();
    t_stack();
    t_imm();
    t_dbl_fixed();
    t_dbl_inc();
    t_dbl_imm();
    t_reject();
    t_dbl_write();
    if (!timed_out) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule